// File: doc/BRIEF.md
# Multichannel ADC Scan Controller

This block is the digital control and sequencing logic for an eight-input successive-approximation converter. A processor reaches it through a small 32-bit register port: address, write strobe, write data and combinational read data. On the other side it drives a converter core. It issues a one-cycle start pulse together with a channel index, the sample-window count and the clock divider setting. The core answers some cycles later with a 12-bit result and a one-cycle done strobe.

Software picks channels in a one-hot select register, powers the block up and releases its soft reset. It then sets the enable bit to run one software-started scan. Selected channels are converted lowest index first, and each result lands in its own result register. A per-channel status bit latches as each channel finishes, and software clears it by writing a one to it. A single level interrupt is the OR of every status bit gated by its enable. Clearing the enable bit during a scan stops the scan. An empty selection raises a dedicated error status bit instead of converting.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0, the mode word (0x04) reads 0x4, the timing word (0x0C) reads 0x000E0578, the divider (0x28) reads 4, and select (0x08), interrupt control (0x20), status (0x24), every result (0x30 + 4n) and the irq output are 0.
- R2: Control bit 15 is the active-high release of soft reset and reads 1 once the release has taken effect. While it reads 0, a write that sets the enable bit (bit 0) starts nothing, and enable and busy (bit 1) stay 0.
- R3: While the power-up bit (control bit 2) is 0, a write that sets the enable bit is ignored. Enable and busy read 0, and no start pulse reaches the converter.
- R4: A scan converts each channel whose select bit (0x08, bits 7:0) is set exactly once, in ascending index order. Each start pulse lasts one cycle and carries the channel index and the timing word bits 15:0.
- R5: From the write that starts a scan, enable and busy both read 1 until the last selected result is stored. Both then clear on the same clock edge.
- R6: The result of channel n reads at 0x30 + 4n in bits 11:0, with bits 31:12 reading 0.
- R7: Status bits 7:0 set when their channel's result is stored and stay set until software writes a 1 to that bit at 0x24. Writing 0 leaves a bit unchanged.
- R8: Setting enable while the select field is 0 sets status bit 16 and converts nothing. Busy and enable stay 0.
- R9: The irq output is high when any status bit n (n < 8) has its enable bit n set at 0x20, or when status bit 16 is set and enable bit 16 at 0x20 is set. Otherwise it is low.
- R10: Writing 0 to the enable bit during a scan stops it. Busy and enable read 0 on the next read, no further start pulse is issued, and a done strobe that arrives later changes neither the results nor the status.
- R11: Writing the select register during a scan does not change which channels that scan converts. The new value reads back afterwards.
- R12: Writable fields read back masked. The mode word keeps bits 0, 2, 4 and 13:12. The timing word keeps all 32 bits (sample count 15:0, compare 23:16, settle 31:24). Interrupt control keeps bits 7:0, 16 and 31. The divider keeps bits 8:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| conv_start | output | 1 | One-cycle conversion request to the converter core |
| conv_chan | output | 3 | Channel index for the current conversion |
| conv_samp | output | 16 | Sample-window count |
| conv_div | output | 9 | Converter clock divider setting |
| conv_done | input | 1 | One-cycle strobe, result valid |
| conv_result | input | 12 | Conversion result |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the converter core raises done only after a start pulse, no more than once per pulse, and holds the result valid with the strobe. They also assume every register write lasts a single cycle. The stand-in core in the bench answers every start with exactly one done after a fixed latency. Its result encodes the channel and a per-test tag, so a stale or misrouted result is visible. The bench issues all register accesses as single-cycle strobes between clock edges. In the stop test the request is aborted while a conversion is outstanding, which exercises the late-strobe case on purpose.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int AW = 8;

    localparam logic [AW-1:0] OFS_CTRL   = 8'h00;
    localparam logic [AW-1:0] OFS_MODE   = 8'h04;
    localparam logic [AW-1:0] OFS_CHSEL  = 8'h08;
    localparam logic [AW-1:0] OFS_TIMING = 8'h0C;
    localparam logic [AW-1:0] OFS_IRQCTL = 8'h20;
    localparam logic [AW-1:0] OFS_STAT   = 8'h24;
    localparam logic [AW-1:0] OFS_CLKDIV = 8'h28;
    localparam logic [AW-1:0] OFS_RES0   = 8'h30;

    localparam int BIT_EN   = 0;
    localparam int BIT_BUSY = 1;
    localparam int BIT_PWR  = 2;
    localparam int BIT_REL  = 15;
    localparam int BIT_CSE  = 16;
    localparam int BIT_IMOD = 31;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_st_e;

endpackage

// File: rtl/adc_seq_sched.sv
module adc_seq_sched
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic [NCH-1:0]  mask,
    input  logic            conv_done,
    output logic            busy,
    output logic            conv_start,
    output logic [CH_W-1:0] cur_chan,
    output logic            res_wr,
    output logic            fin
);

    typedef struct packed {
        seq_st_e          st;
        logic [NCH-1:0]   pend;
        logic [CH_W-1:0]  cur;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [CH_W-1:0] lowest(input logic [NCH-1:0] m);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) r = CH_W'(i);
        end
        return r;
    endfunction

    logic [NCH-1:0] rest;
    logic           wr_raw;

    always_comb begin
        s_d    = s_q;
        wr_raw = 1'b0;
        fin    = 1'b0;
        rest   = s_q.pend & ~(NCH'(1) << s_q.cur);
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start && (|mask)) begin
                    s_d.pend = mask;
                    s_d.cur  = lowest(mask);
                    s_d.st   = SQ_REQ;
                end
            end
            SQ_REQ: begin
                s_d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (conv_done) begin
                    wr_raw   = 1'b1;
                    s_d.pend = rest;
                    if (rest == '0) begin
                        fin      = 1'b1;
                        s_d.st   = SQ_IDLE;
                    end else begin
                        s_d.cur  = lowest(rest);
                        s_d.st   = SQ_REQ;
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
        if (abort) begin
            s_d.st   = SQ_IDLE;
            s_d.pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, pend: '0, cur: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st != SQ_IDLE);
    assign conv_start = (s_q.st == SQ_REQ) && !abort;
    assign cur_chan   = s_q.cur;
    assign res_wr     = wr_raw && !abort;

endmodule

// File: rtl/adc_seq_resbank.sv
module adc_seq_resbank #(
    parameter int NCH   = 8,
    parameter int RES_W = 12,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_idx,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_idx,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] vals [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [RES_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == CH_W'(g))) val_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign vals[g] = val_q;
    end

    assign rd_data = vals[rd_idx];

endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] sts,
    input  logic [NCH-1:0] inten,
    input  logic           cse,
    input  logic           cse_en,
    output logic           irq
);

    logic [NCH:0] hit;

    for (genvar g = 0; g < NCH; g++) begin : g_src
        assign hit[g] = sts[g] & inten[g];
    end
    assign hit[NCH] = cse & cse_en;

    assign irq = |hit;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int              NCH      = 8,
    parameter int              RES_W    = 12,
    parameter int              SAMP_W   = 16,
    parameter int              DIV_W    = 9,
    parameter logic [15:0]     SAMP_RST = 16'h0578,
    parameter logic [7:0]      CMP_RST  = 8'h0E,
    parameter logic [8:0]      DIV_RST  = 9'd4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                reg_addr,
    input  logic                      reg_wr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      conv_start,
    output logic [$clog2(NCH)-1:0]    conv_chan,
    output logic [SAMP_W-1:0]         conv_samp,
    output logic [DIV_W-1:0]          conv_div,
    input  logic                      conv_done,
    input  logic [RES_W-1:0]          conv_result,
    output logic                      irq
);

    localparam int CH_W = $clog2(NCH);
    localparam int FW   = 8;
    localparam logic [AW-1:0] RES_END = OFS_RES0 + AW'(4 * NCH);

    typedef struct packed {
        logic               en;
        logic               pwr;
        logic               rel_req;
        logic               rel_ack;
        logic               trg_hw;
        logic               scan;
        logic               bufm;
        logic [1:0]         edge_sel;
        logic [NCH-1:0]     chsel;
        logic [SAMP_W-1:0]  samp;
        logic [FW-1:0]      cmp;
        logic [FW-1:0]      settle;
        logic [NCH-1:0]     inten;
        logic               cse_en;
        logic               imode;
        logic [NCH-1:0]     sts;
        logic               cse;
        logic [DIV_W-1:0]   div;
    } regs_t;

    regs_t r_d, r_q;

    logic            busy;
    logic            seq_start;
    logic            seq_abort;
    logic            seq_fin;
    logic            res_wr;
    logic [CH_W-1:0] cur_chan;
    logic [CH_W-1:0] rd_idx;
    logic [RES_W-1:0] rd_res;

    logic wr_ctrl, gate_ok, start_req, cse_set;
    logic [NCH-1:0] sts_set;

    // Scan control decisions for this cycle
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
        gate_ok   = r_q.pwr && r_q.rel_ack;
        start_req = wr_ctrl && reg_wdata[BIT_EN] && !busy && gate_ok;
        seq_start = start_req && (|r_q.chsel);
        cse_set   = start_req && !(|r_q.chsel);
        seq_abort = busy && (!gate_ok || (wr_ctrl && !reg_wdata[BIT_EN]));
        sts_set   = res_wr ? (NCH'(1) << cur_chan) : '0;
    end

    // Next-state computation for all registers
    always_comb begin
        r_d = r_q;
        r_d.rel_ack = r_q.rel_req;

        if (reg_wr) begin
            unique case (reg_addr)
                OFS_CTRL: begin
                    r_d.pwr     = reg_wdata[BIT_PWR];
                    r_d.rel_req = reg_wdata[BIT_REL];
                end
                OFS_MODE: begin
                    r_d.trg_hw   = reg_wdata[0];
                    r_d.scan     = reg_wdata[2];
                    r_d.bufm     = reg_wdata[4];
                    r_d.edge_sel = reg_wdata[13:12];
                end
                OFS_CHSEL:  r_d.chsel = reg_wdata[NCH-1:0];
                OFS_TIMING: begin
                    r_d.samp   = reg_wdata[SAMP_W-1:0];
                    r_d.cmp    = reg_wdata[23:16];
                    r_d.settle = reg_wdata[31:24];
                end
                OFS_IRQCTL: begin
                    r_d.inten  = reg_wdata[NCH-1:0];
                    r_d.cse_en = reg_wdata[BIT_CSE];
                    r_d.imode  = reg_wdata[BIT_IMOD];
                end
                OFS_STAT: begin
                    r_d.sts = r_q.sts & ~reg_wdata[NCH-1:0];
                    r_d.cse = r_q.cse & ~reg_wdata[BIT_CSE];
                end
                OFS_CLKDIV: r_d.div = reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end

        r_d.sts = r_d.sts | sts_set;
        if (cse_set) r_d.cse = 1'b1;

        if (seq_start)            r_d.en = 1'b1;
        if (seq_fin || seq_abort) r_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.scan     <= 1'b1;
            r_q.samp     <= SAMP_W'(SAMP_RST);
            r_q.cmp      <= CMP_RST;
            r_q.div      <= DIV_W'(DIV_RST);
        end else begin
            r_q <= r_d;
        end
    end

    // Read mux
    assign rd_idx = CH_W'((reg_addr - OFS_RES0) >> 2);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[BIT_EN]   = r_q.en;
                reg_rdata[BIT_BUSY] = busy;
                reg_rdata[BIT_PWR]  = r_q.pwr;
                reg_rdata[BIT_REL]  = r_q.rel_ack;
            end
            OFS_MODE: begin
                reg_rdata[0]     = r_q.trg_hw;
                reg_rdata[2]     = r_q.scan;
                reg_rdata[4]     = r_q.bufm;
                reg_rdata[13:12] = r_q.edge_sel;
            end
            OFS_CHSEL:  reg_rdata[NCH-1:0] = r_q.chsel;
            OFS_TIMING: reg_rdata = {r_q.settle, r_q.cmp, r_q.samp};
            OFS_IRQCTL: begin
                reg_rdata[NCH-1:0] = r_q.inten;
                reg_rdata[BIT_CSE]  = r_q.cse_en;
                reg_rdata[BIT_IMOD] = r_q.imode;
            end
            OFS_STAT: begin
                reg_rdata[NCH-1:0] = r_q.sts;
                reg_rdata[BIT_CSE]  = r_q.cse;
            end
            OFS_CLKDIV: reg_rdata[DIV_W-1:0] = r_q.div;
            default: begin
                if ((reg_addr >= OFS_RES0) && (reg_addr < RES_END) &&
                    (reg_addr[1:0] == 2'b00)) begin
                    reg_rdata[RES_W-1:0] = rd_res;
                end
            end
        endcase
    end

    adc_seq_sched #(.NCH(NCH), .CH_W(CH_W)) sched_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .abort      (seq_abort),
        .mask       (r_q.chsel),
        .conv_done  (conv_done),
        .busy       (busy),
        .conv_start (conv_start),
        .cur_chan   (cur_chan),
        .res_wr     (res_wr),
        .fin        (seq_fin)
    );

    adc_seq_resbank #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) resbank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr),
        .wr_idx  (cur_chan),
        .wr_data (conv_result),
        .rd_idx  (rd_idx),
        .rd_data (rd_res)
    );

    adc_seq_irq #(.NCH(NCH)) irq_i (
        .sts    (r_q.sts),
        .inten  (r_q.inten),
        .cse    (r_q.cse),
        .cse_en (r_q.cse_en),
        .irq    (irq)
    );

    assign conv_chan = cur_chan;
    assign conv_samp = r_q.samp;
    assign conv_div  = r_q.div;

    // Named views for the bound checker
    logic           pwr_w, rel_w, en_w, busy_w;
    logic [NCH-1:0] sts_w;
    assign pwr_w  = r_q.pwr;
    assign rel_w  = r_q.rel_ack;
    assign en_w   = r_q.en;
    assign busy_w = busy;
    assign sts_w  = r_q.sts;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr,
    input logic           pwr_w,
    input logic           rel_w,
    input logic           en_w,
    input logic           busy_w,
    input logic           conv_start,
    input logic [NCH-1:0] sts_w
);

    AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_w || !rel_w) |=> !busy_w); // R3

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R4

    AST_START_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy_w); // R5

    AST_BUSY_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> en_w); // R5

    AST_EN_FALLS_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w) |-> !en_w); // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((sts_w & $past(sts_w)) == $past(sts_w))); // R7

endmodule

bind adc_seq_ctrl adc_seq_chk #(.NCH(NCH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .pwr_w      (pwr_w),
    .rel_w      (rel_w),
    .en_w       (en_w),
    .busy_w     (busy_w),
    .conv_start (conv_start),
    .sts_w      (sts_w)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

    localparam int LAT   = 4;
    localparam int NVEC  = 6;
    localparam int LOG_N = 64;

    localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_CHSEL = 8'h08,
                           A_TIM = 8'h0C, A_IRQ = 8'h20, A_STAT = 8'h24,
                           A_DIV = 8'h28, A_RES0 = 8'h30;

    // Stimulus/expectation table: select mask, result tag, expected conversions
    localparam logic [7:0] VEC_MASK [NVEC] = '{8'h01, 8'h80, 8'hA5, 8'hFF, 8'h3C, 8'h42};
    localparam logic [7:0] VEC_TAG  [NVEC] = '{8'h17, 8'hC3, 8'h5E, 8'h99, 8'h0F, 8'hE1};
    localparam int         VEC_CNT  [NVEC] = '{1, 1, 4, 8, 4, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_start;
    logic [2:0]  conv_chan;
    logic [15:0] conv_samp;
    logic [8:0]  conv_div;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .conv_samp   (conv_samp),
        .conv_div    (conv_div),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .irq         (irq)
    );

    // Behavioural converter core
    logic [7:0]  tag = '0;
    logic [2:0]  st_ch = '0;
    int          cnt = 0;
    logic [2:0]  log_ch [LOG_N];
    int          log_n = 0;
    logic [15:0] samp_seen = '0;

    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            cnt   <= 0;
            log_n <= 0;
        end else if (conv_start) begin
            cnt   <= LAT;
            st_ch <= conv_chan;
            if (log_n < LOG_N) log_ch[log_n] <= conv_chan;
            log_n     <= log_n + 1;
            samp_seen <= conv_samp;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= {1'b0, st_ch, tag};
            end
        end
    end

    function automatic logic [31:0] exp_res(input int ch, input logic [7:0] t);
        return {20'h0, 1'b0, 3'(ch), t};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        bit done = 0;
        for (int i = 0; i < 400 && !done; i++) begin
            rd(A_CTRL, v);
            if (!v[1]) done = 1;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL %s actual busy expected idle", req);
        end
    endtask

    task automatic run_scan(input logic [7:0] m, input logic [7:0] t);
        tag = t;
        wr(A_STAT, 32'h0001_FFFF);
        wr(A_CHSEL, {24'h0, m});
        wr(A_CTRL, 32'h0000_8005);
        wait_idle("R5");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] s;
        int base, idx;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(A_MODE, v);  chk("R1 mode", v, 32'h4);
        rd(A_CHSEL, v); chk("R1 chsel", v, 32'h0);
        rd(A_TIM, v);   chk("R1 timing", v, 32'h000E_0578);
        rd(A_IRQ, v);   chk("R1 irqctl", v, 32'h0);
        rd(A_STAT, v);  chk("R1 status", v, 32'h0);
        rd(A_DIV, v);   chk("R1 divider", v, 32'h4);
        for (int ch = 0; ch < 8; ch++) begin
            rd(A_RES0 + 8'(4 * ch), v); chk("R1 result", v, 32'h0);
        end
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R3: powered down, soft reset held
        wr(A_CHSEL, 32'h1);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); chk("R3 start ignored unpowered", v, 32'h0);
        wr(A_CTRL, 32'h8001);
        rd(A_CTRL, v); chk("R3 release but still unpowered", v, 32'h8000);
        wr(A_CTRL, 32'h8005);
        rd(A_CTRL, v); chk("R3 power written, start ignored", v, 32'h8004);
        chk("R3 no start pulse", 32'(log_n), 32'h0);

        // R2: powered up but soft reset held
        wr(A_CTRL, 32'h0004);
        wr(A_CTRL, 32'h0005);
        rd(A_CTRL, v); chk("R2 start ignored in soft reset", v, 32'h0004);
        chk("R2 no start pulse", 32'(log_n), 32'h0);
        wr(A_CTRL, 32'h8004);
        rd(A_CTRL, v); chk("R2 release reads back", v, 32'h8004);

        // R12: field masking
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_MODE, v); chk("R12 mode mask", v, 32'h0000_3015);
        wr(A_MODE, 32'h4);
        wr(A_IRQ, 32'hFFFF_FFFF);
        rd(A_IRQ, v); chk("R12 irqctl mask", v, 32'h8001_00FF);
        wr(A_IRQ, 32'h0);
        wr(A_TIM, 32'hFFFF_FFFF);
        rd(A_TIM, v); chk("R12 timing", v, 32'hFFFF_FFFF);
        wr(A_TIM, 32'h000E_0578);
        wr(A_DIV, 32'hFFFF);
        rd(A_DIV, v); chk("R12 divider mask", v, 32'h1FF);
        wr(A_DIV, 32'h4);

        // Vector walk: R4 R5 R6 R7
        for (int k = 0; k < NVEC; k++) begin
            tag = VEC_TAG[k];
            wr(A_STAT, 32'h0001_FFFF);
            wr(A_CHSEL, {24'h0, VEC_MASK[k]});
            base = log_n;
            wr(A_CTRL, 32'h8005);
            rd(A_CTRL, v); chk("R5 enable and busy during scan", v, 32'h8007);
            wait_idle("R5");
            rd(A_CTRL, v); chk("R5 enable and busy clear together", v, 32'h8004);
            rd(A_STAT, v); chk("R7 status per channel", v, {24'h0, VEC_MASK[k]});
            chk("R4 conversion count", 32'(log_n - base), 32'(VEC_CNT[k]));
            idx = 0;
            for (int ch = 0; ch < 8; ch++) begin
                if (VEC_MASK[k][ch]) begin
                    if (base + idx < LOG_N)
                        chk("R4 ascending order", {29'h0, log_ch[base + idx]}, 32'(ch));
                    idx++;
                    rd(A_RES0 + 8'(4 * ch), v);
                    chk("R6 result value", v, exp_res(ch, VEC_TAG[k]));
                end
            end
            chk("R4 sample count to core", {16'h0, samp_seen}, 32'h0578);
        end

        // R8: empty selection
        wr(A_STAT, 32'h0001_FFFF);
        wr(A_CHSEL, 32'h0);
        base = log_n;
        wr(A_CTRL, 32'h8005);
        rd(A_CTRL, v); chk("R8 no scan on empty select", v, 32'h8004);
        rd(A_STAT, v); chk("R8 select error status", v, 32'h0001_0000);
        chk("R8 no conversion", 32'(log_n - base), 32'h0);

        // R9: interrupt combining
        @(negedge clk); #1; chk("R9 irq masked", {31'h0, irq}, 32'h0);
        wr(A_IRQ, 32'h0001_0000);
        #1; chk("R9 irq from select error", {31'h0, irq}, 32'h1);
        wr(A_STAT, 32'h0001_0000);
        #1; chk("R9 irq after clear", {31'h0, irq}, 32'h0);
        run_scan(8'h42, 8'h33);
        wr(A_IRQ, 32'h02);
        #1; chk("R9 irq channel 1", {31'h0, irq}, 32'h1);
        wr(A_IRQ, 32'h80);
        #1; chk("R9 irq other enable", {31'h0, irq}, 32'h0);
        wr(A_STAT, 32'h02);
        rd(A_STAT, v); chk("R7 write one clears only that bit", v, 32'h40);
        wr(A_IRQ, 32'h40);
        #1; chk("R9 irq channel 6", {31'h0, irq}, 32'h1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R7 write zero keeps bits", v, 32'h40);
        wr(A_STAT, 32'h40);
        #1; chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        wr(A_IRQ, 32'h0);

        // R11: select written during scan
        tag = 8'h5A;
        wr(A_STAT, 32'h0001_FFFF);
        wr(A_CHSEL, 32'h05);
        base = log_n;
        wr(A_CTRL, 32'h8005);
        wr(A_CHSEL, 32'hF0);
        wait_idle("R11");
        rd(A_STAT, v); chk("R11 scan kept old select", v, 32'h05);
        chk("R11 conversion count", 32'(log_n - base), 32'h2);
        rd(A_CHSEL, v); chk("R11 new select reads back", v, 32'hF0);

        // R10: stop in the middle of a scan
        run_scan(8'hFF, 8'h11);
        tag = 8'h22;
        wr(A_STAT, 32'h0001_FFFF);
        wr(A_CHSEL, 32'hFF);
        wr(A_CTRL, 32'h8005);
        s = '0;
        for (int i = 0; i < 200 && !s[0]; i++) rd(A_STAT, s);
        wr(A_CTRL, 32'h8004);
        rd(A_CTRL, v); chk("R10 stopped", v, 32'h8004);
        base = log_n;
        repeat (20) @(negedge clk);
        chk("R10 no start after stop", 32'(log_n), 32'(base));
        rd(A_STAT, s);
        chk("R10 scan not finished", {31'h0, s[7]}, 32'h0);
        for (int ch = 0; ch < 8; ch++) begin
            rd(A_RES0 + 8'(4 * ch), v);
            chk("R10 results consistent with status", v,
                s[ch] ? exp_res(ch, 8'h22) : exp_res(ch, 8'h11));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule